// File: doc/BRIEF.md
# Graceful Stop and Transmit Poll Controller

This block turns writes to a DMA control register into two kinds of activity. For receive and for transmit it handles an orderly halt. When software sets a direction's stop bit, the block raises a one-cycle stop-complete strobe. If that direction has a frame in flight, the strobe waits for the frame to end. If not, it fires straight away.

The block also runs a poll timer. A control write with the wait-on-poll bit clear restarts the timer from a count of one. Each time the timer expires it issues a one-cycle kick to the ring-0 transmit descriptor walker, unless a transmit stop is in force. Setting wait-on-poll lets the timer run out once more and then halt, with no kick on that last expiry.

The poll period is a parameter in clock cycles. The nominal rate is 100 polls per second, which gives 2,000,000 cycles at 200 MHz. The descriptor walkers themselves sit outside this block.

Top module: `stop_poll_ctl`

## Requirements
- R1: After reset all three outputs are low, and the poll timer stays idle (no `ring0_kick`) until a control write with `ctl_poll_wait`=0.
- R2: A control write with `ctl_rx_stop`=1 while `rx_busy`=0 makes `rx_stop_done` high for exactly the one cycle after the write edge.
- R3: A control write with `ctl_rx_stop`=1 while `rx_busy`=1 (and no `rx_eof`) holds the strobe back. `rx_stop_done` then pulses in the cycle after the first later `rx_eof`.
- R4: The transmit side behaves like R2 and R3, using `ctl_tx_stop`, `tx_busy`, `tx_eof` and `tx_stop_done`.
- R5: A control write that clears a direction's stop bit while its completion is still held back cancels it: the following end-of-frame strobe produces no stop-complete pulse.
- R6: A write with a stop bit of 0 gives no stop-complete pulse, and an end-of-frame strobe with nothing held back gives none either.
- R7: A control write with `ctl_poll_wait`=0 restarts the timer at a count of one. The timer therefore expires in the cycle after the write, and `ring0_kick` is high in the second cycle after the write edge (when transmit stop is clear).
- R8: While wait-on-poll stays clear, the timer re-arms on every expiry, and kicks are exactly POLL_CYCLES cycles apart.
- R9: An expiry while the registered transmit stop bit is 1 re-arms the timer but issues no kick.
- R10: An expiry while the registered wait-on-poll bit is 1 stops the timer without a kick. No further kicks follow until the next write with `ctl_poll_wait`=0.
- R11: A control write in the same cycle as an event is resolved as follows:
  - A stop request made while the frame is busy and its end-of-frame strobe is high completes at once.
  - A timer expiry decides on kick and re-arm from the register values held before a write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_rx_stop | input | 1 | Written graceful receive stop bit |
| ctl_tx_stop | input | 1 | Written graceful transmit stop bit |
| ctl_poll_wait | input | 1 | Written wait-on-poll bit (1 = stop polling) |
| rx_busy | input | 1 | Receive frame in progress |
| tx_busy | input | 1 | Transmit frame in progress |
| rx_eof | input | 1 | Receive end-of-frame strobe |
| tx_eof | input | 1 | Transmit end-of-frame strobe |
| rx_stop_done | output | 1 | Receive-stop-complete event set strobe |
| tx_stop_done | output | 1 | Transmit-stop-complete event set strobe |
| ring0_kick | output | 1 | Start pulse for the ring-0 transmit descriptor walk |

## Verification
Two coincidences can fall in the same cycle, and both are provoked on purpose.

The first is a stop request and the end-of-frame strobe of the busy frame arriving together. The bench drives both in one cycle and expects the completion pulse in the very next cycle.

The second is a control write landing exactly on a timer expiry. The bench issues a poll-start write, then immediately writes wait-on-poll as 1, which puts the second write in the expiry cycle. The expiry must still kick, judged on the old register value, and the following expiry must halt the timer without a kick.

Random traffic then mixes writes, busy flags and end-of-frame strobes. A cycle model in the bench judges every output in every cycle.

// File: rtl/stop_poll_pkg.sv
package stop_poll_pkg;

    localparam int unsigned DIR_RX  = 0;
    localparam int unsigned DIR_TX  = 1;
    localparam int unsigned NUM_DIR = 2;

    typedef struct packed {
        logic stop;   // registered stop bit
        logic pend;   // completion held back until end of frame
        logic done;   // completion strobe
    } gstop_st_t;

endpackage

// File: rtl/gstop_track.sv
module gstop_track
    import stop_poll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic bit_i,
    input  logic busy_i,
    input  logic eof_i,
    output logic stop_o,
    output logic done_o
);

    gstop_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (wr_i) begin
            st_d.stop = bit_i;
            if (!bit_i) begin
                st_d.pend = 1'b0;
            end else if (!busy_i || eof_i) begin
                st_d.done = 1'b1;
                st_d.pend = 1'b0;
            end else begin
                st_d.pend = 1'b1;
            end
        end else if (st_q.pend && eof_i) begin
            st_d.done = 1'b1;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stop_o = st_q.stop;
    assign done_o = st_q.done;

    // R2: a completion is only ever reported with the stop bit set
    assert_done_with_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> st_q.stop);

    // R3: a held-back request waits while no write and no end of frame arrive
    assert_pend_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !wr_i && !eof_i) |=> (st_q.pend && !st_q.done));

    // R5: clearing the stop bit drops any held-back completion
    assert_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !bit_i) |=> (!st_q.done && !st_q.pend));

endmodule

// File: rtl/poll_tick.sv
module poll_tick #(
    parameter int unsigned POLL_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wait_bit_i,
    input  logic hold_i,
    output logic kick_o
);

    localparam int unsigned CW = $clog2(POLL_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(POLL_CYCLES);
    localparam logic [CW-1:0] ONE    = CW'(1);

    typedef struct packed {
        logic          run;
        logic          wt;
        logic          kick;
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t tk_d, tk_q;
    logic     expire;

    always_comb begin
        expire    = tk_q.run && (tk_q.cnt == ONE);
        tk_d      = tk_q;
        tk_d.kick = 1'b0;
        if (expire) begin
            if (!tk_q.wt) begin
                tk_d.cnt  = RELOAD;
                tk_d.kick = !hold_i;
            end else begin
                tk_d.run = 1'b0;
            end
        end else if (tk_q.run) begin
            tk_d.cnt = tk_q.cnt - ONE;
        end
        if (wr_i) begin
            tk_d.wt = wait_bit_i;
            if (!wait_bit_i) begin
                tk_d.run = 1'b1;
                tk_d.cnt = ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tk_q <= '0;
        else        tk_q <= tk_d;
    end

    assign kick_o = tk_q.kick;

    // R1: an idle timer cannot produce a kick in the next cycle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tk_q.run |=> !tk_q.kick);

    // R8: a kick re-arms the timer, which keeps running
    assert_kick_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tk_q.kick |-> tk_q.run);

    // R10: expiry with wait-on-poll set halts without a kick
    assert_wait_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && tk_q.wt && !wr_i) |=> (!tk_q.run && !tk_q.kick));

endmodule

// File: rtl/stop_poll_ctl.sv
module stop_poll_ctl
    import stop_poll_pkg::*;
#(
    parameter int unsigned POLL_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_rx_stop,
    input  logic ctl_tx_stop,
    input  logic ctl_poll_wait,
    input  logic rx_busy,
    input  logic tx_busy,
    input  logic rx_eof,
    input  logic tx_eof,
    output logic rx_stop_done,
    output logic tx_stop_done,
    output logic ring0_kick
);

    logic [NUM_DIR-1:0] bit_v, busy_v, eof_v, stop_v, done_v;

    assign bit_v  = {ctl_tx_stop, ctl_rx_stop};
    assign busy_v = {tx_busy, rx_busy};
    assign eof_v  = {tx_eof, rx_eof};

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        gstop_track u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_i   (ctl_wr),
            .bit_i  (bit_v[d]),
            .busy_i (busy_v[d]),
            .eof_i  (eof_v[d]),
            .stop_o (stop_v[d]),
            .done_o (done_v[d])
        );
    end

    poll_tick #(.POLL_CYCLES(POLL_CYCLES)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (ctl_wr),
        .wait_bit_i (ctl_poll_wait),
        .hold_i     (stop_v[DIR_TX]),
        .kick_o     (ring0_kick)
    );

    assign rx_stop_done = done_v[DIR_RX];
    assign tx_stop_done = done_v[DIR_TX];

    // R9: no kick may follow a cycle in which transmit stop was registered
    assert_kick_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ring0_kick |-> !$past(stop_v[DIR_TX]));

    // R4: transmit completion only with transmit stop held
    assert_tx_done_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stop_done |-> stop_v[DIR_TX]);

endmodule

// File: tb/stop_poll_ctl_tb.sv
module stop_poll_ctl_tb;

    localparam int unsigned PER = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 0, ctl_rx_stop = 0, ctl_tx_stop = 0, ctl_poll_wait = 0;
    logic rx_busy = 0, tx_busy = 0, rx_eof = 0, tx_eof = 0;
    logic rx_stop_done, tx_stop_done, ring0_kick;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // bench model state
    logic m_rs, m_rp, m_ts, m_tp, m_wt, m_run;
    int   m_cnt;
    logic e_rx, e_tx, e_kick;

    always #2.5 clk = ~clk;

    stop_poll_ctl #(.POLL_CYCLES(PER)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rx_stop(ctl_rx_stop),
        .ctl_tx_stop(ctl_tx_stop), .ctl_poll_wait(ctl_poll_wait),
        .rx_busy(rx_busy), .tx_busy(tx_busy), .rx_eof(rx_eof), .tx_eof(tx_eof),
        .rx_stop_done(rx_stop_done), .tx_stop_done(tx_stop_done),
        .ring0_kick(ring0_kick)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // stop tracker expectation, written from R2..R6 and R11
    task automatic trk(inout logic stop, inout logic pend, output logic done,
                       input logic wr, input logic b, input logic busy, input logic eof);
        done = 1'b0;
        if (wr) begin
            stop = b;
            if (!b) pend = 1'b0;
            else if (!busy || eof) begin done = 1'b1; pend = 1'b0; end
            else pend = 1'b1;
        end else if (pend && eof) begin
            done = 1'b1; pend = 1'b0;
        end
    endtask

    task automatic model_reset();
        m_rs = 0; m_rp = 0; m_ts = 0; m_tp = 0; m_wt = 0; m_run = 0; m_cnt = 0;
        e_rx = 0; e_tx = 0; e_kick = 0;
    endtask

    task automatic cyc(input logic wr, input logic rs, input logic ts, input logic w,
                       input logic rb, input logic tb, input logic re, input logic te,
                       input string tag);
        logic old_ts, exp_now;
        ctl_wr = wr; ctl_rx_stop = rs; ctl_tx_stop = ts; ctl_poll_wait = w;
        rx_busy = rb; tx_busy = tb; rx_eof = re; tx_eof = te;
        old_ts = m_ts;
        // timer expectation from R7..R11
        exp_now = m_run && (m_cnt == 1);
        e_kick = exp_now && !m_wt && !old_ts;
        if (exp_now) begin
            if (!m_wt) m_cnt = PER;
            else m_run = 0;
        end else if (m_run) m_cnt = m_cnt - 1;
        if (wr) begin
            m_wt = w;
            if (!w) begin m_run = 1; m_cnt = 1; end
        end
        trk(m_rs, m_rp, e_rx, wr, rs, rb, re);
        trk(m_ts, m_tp, e_tx, wr, ts, tb, te);
        @(posedge clk);
        @(negedge clk);
        chk(rx_stop_done, e_rx, {tag, " rx_stop_done"});
        chk(tx_stop_done, e_tx, {tag, " tx_stop_done"});
        chk(ring0_kick, e_kick, {tag, " ring0_kick"});
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state and idle timer
        chk(rx_stop_done, 0, "R1 reset rx");
        chk(tx_stop_done, 0, "R1 reset tx");
        chk(ring0_kick, 0, "R1 reset kick");
        idle(40, "R1 idle");

        // R2 immediate receive stop
        cyc(1, 1, 0, 1, 0, 0, 0, 0, "R2 write");
        chk(rx_stop_done, 1, "R2 pulse");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R2 one cycle");
        chk(rx_stop_done, 0, "R2 single");

        // R3 deferred receive stop
        cyc(1, 1, 0, 1, 1, 0, 0, 0, "R3 write busy");
        chk(rx_stop_done, 0, "R3 held");
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 0, 0, 0, "R3 wait");
        cyc(0, 0, 0, 0, 1, 0, 1, 0, "R3 eof");
        chk(rx_stop_done, 1, "R3 done");
        cyc(0, 0, 0, 0, 0, 0, 1, 0, "R6 eof nothing held");

        // R4 transmit stop, deferred then immediate
        cyc(1, 0, 1, 1, 0, 1, 0, 0, "R4 write busy");
        idle(3, "R4 wait");
        cyc(0, 0, 0, 0, 0, 1, 0, 1, "R4 eof");
        chk(tx_stop_done, 1, "R4 done");
        cyc(1, 0, 1, 1, 0, 0, 0, 0, "R4 immediate");
        chk(tx_stop_done, 1, "R4 immediate pulse");

        // R5 cancel held completion
        cyc(1, 1, 0, 1, 1, 0, 0, 0, "R5 write busy");
        cyc(1, 0, 0, 1, 1, 0, 0, 0, "R5 clear");
        cyc(0, 0, 0, 0, 1, 0, 1, 0, "R5 eof");
        chk(rx_stop_done, 0, "R5 cancelled");

        // R6 stop bit zero
        cyc(1, 0, 0, 1, 0, 0, 0, 0, "R6 zero write");
        chk(rx_stop_done, 0, "R6 no rx");

        // R11 request and frame end in one cycle
        cyc(1, 1, 0, 1, 1, 0, 1, 0, "R11 same cycle");
        chk(rx_stop_done, 1, "R11 immediate");

        // R7 and R8 polling
        cyc(1, 0, 0, 0, 0, 0, 0, 0, "R7 start");
        chk(ring0_kick, 0, "R7 not yet");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R7 first kick");
        chk(ring0_kick, 1, "R7 kick");
        idle(PER - 1, "R8 gap");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R8 period");
        chk(ring0_kick, 1, "R8 second kick");

        // R9 transmit stop gates kicks
        cyc(1, 0, 1, 0, 0, 0, 0, 0, "R9 write");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R9 expiry");
        chk(ring0_kick, 0, "R9 gated");
        idle(3 * PER, "R9 gated run");

        // R10 wait-on-poll halts
        cyc(1, 0, 0, 0, 0, 0, 0, 0, "R10 restart");
        cyc(1, 0, 0, 1, 0, 0, 0, 0, "R11 write on expiry");
        chk(ring0_kick, 1, "R11 old values decide");
        idle(PER, "R10 halting expiry");
        idle(3 * PER, "R10 halted");
        chk(ring0_kick, 0, "R10 no kick");

        // random mix, judged by the model
        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 8) == 0, $urandom % 2, ($urandom % 4) == 0, ($urandom % 3) == 0,
                $urandom % 2, $urandom % 2, ($urandom % 4) == 0, ($urandom % 4) == 0,
                "R11 random");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule